// File: doc/BRIEF.md
# Escaped Packet Receive Deframer

The deframer sits behind a UART receiver and turns its byte stream into packets. The sender opens a packet with two start codes and closes it with one end code. An escape code placed before a byte forces that byte to be read as data. This lets payload values that match a control code pass through the link.

Each data byte is written into a byte buffer as soon as it arrives, at an address equal to its position in the packet. The last data byte before the end code is a checksum. The packet is good when all data bytes, the checksum included, sum to zero modulo 256. When a good packet closes, the block reports its length, which leaves out the checksum byte. A failed check raises a separate bad-packet pulse instead.

An end code that comes straight after the start pair closes an empty packet. This writes nothing, so the buffer keeps the previous packet for reuse. A packet longer than the data limit is dropped, and the block hunts for the next start pair.

Top module: `esc_pkt_deframer`

## Requirements
- R1: A packet opens only when two unescaped start codes (0x0F) arrive back to back. A lone 0x0F followed by any other byte opens nothing, and later bytes up to the next start pair produce no write and no pulse.
- R2: The k-th data byte of a packet (k counted from 0) is written with wr_en high, wr_addr = k and wr_data = the byte, one clock after the byte is accepted.
- R3: An escape code (0x05) inside a packet is dropped. The byte that follows it is handled as data even when it equals 0x0F, 0x04 or 0x05.
- R4: An unescaped end code (0x04) closes the packet. If the checksum holds, pkt_done pulses for one cycle, one clock after the end code, with pkt_len = number of data bytes minus one.
- R5: The checksum holds when the 8-bit sum of all data bytes, the checksum byte included, is zero. Control codes and escape prefixes are not added. On a mismatch, pkt_bad pulses instead and pkt_done stays low.
- R6: An end code directly after the start pair gives pkt_done with pkt_len = 0 and no buffer write.
- R7: Data byte number 256 of a packet (MAX_DATA = 255) is not written. It raises a one-cycle overflow pulse, and the block then ignores input until a start pair arrives, so a later end code reports nothing.
- R8: An unescaped start code inside a packet abandons that packet. If a second start code follows, a new packet opens with its byte count back at zero.
- R9: During reset, wr_en, pkt_done, pkt_bad and overflow are low.
- R10: A cycle with in_valid low changes no state, and no write or pulse follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | in_byte holds a received byte |
| in_byte | input | 8 | Received byte |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 8 | Buffer write address |
| wr_data | output | 8 | Buffer write data |
| pkt_done | output | 1 | Good packet closed (pulse) |
| pkt_bad | output | 1 | Packet closed with a checksum mismatch (pulse) |
| pkt_len | output | 8 | Data length without the checksum, valid with pkt_done |
| overflow | output | 1 | Packet dropped for excess length (pulse) |

## Verification
Escape handling and the length limit can act on the same byte: an escaped byte may be the one that exceeds the limit. The bench provokes this with 255 zero data bytes followed by an escape and 0x0F. It expects exactly 255 writes, one overflow pulse and no packet pulse from the end code that follows. Random packets containing stuffed control values, corrupted checksums and idle gaps are compared against checksums and buffer images computed in the bench.

// File: rtl/esc_pkt_pkg.sv
package esc_pkt_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_PAIR = 2'd1,
        ST_BODY = 2'd2,
        ST_ESC  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/esc_pkt_class.sv
module esc_pkt_class #(
    parameter int          DW         = 8,
    parameter logic [DW-1:0] START_CODE = 8'h0F,
    parameter logic [DW-1:0] END_CODE   = 8'h04,
    parameter logic [DW-1:0] ESC_CODE   = 8'h05
) (
    input  logic [DW-1:0] byte_i,
    output logic          is_start,
    output logic          is_end,
    output logic          is_esc
);
    always_comb begin
        is_start = (byte_i == START_CODE);
        is_end   = (byte_i == END_CODE);
        is_esc   = (byte_i == ESC_CODE);
    end
endmodule

// File: rtl/esc_pkt_sum.sv
module esc_pkt_sum #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] sum_q,
    output logic          zero
);
    logic [DW-1:0] sum_d;

    always_comb begin
        sum_d = sum_q;
        if (clr)
            sum_d = '0;
        else if (add)
            sum_d = sum_q + din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sum_q <= '0;
        else
            sum_q <= sum_d;
    end

    assign zero = (sum_q == '0);

    // R5: a clear leaves an empty running sum
    p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum_q == '0));
endmodule

// File: rtl/esc_pkt_deframer.sv
module esc_pkt_deframer
    import esc_pkt_pkg::*;
#(
    parameter int            DW         = 8,
    parameter int            MAX_DATA   = 255,
    parameter logic [DW-1:0] START_CODE = 8'h0F,
    parameter logic [DW-1:0] END_CODE   = 8'h04,
    parameter logic [DW-1:0] ESC_CODE   = 8'h05,
    localparam int           CW         = $clog2(MAX_DATA + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    output logic          wr_en,
    output logic [CW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          pkt_done,
    output logic          pkt_bad,
    output logic [CW-1:0] pkt_len,
    output logic          overflow
);
    typedef struct packed {
        rx_state_e     state;
        logic [CW-1:0] cnt;
        logic          wr_en;
        logic [CW-1:0] wr_addr;
        logic [DW-1:0] wr_data;
        logic          done;
        logic          bad;
        logic [CW-1:0] len;
        logic          ovf;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic          is_start, is_end, is_esc;
    logic          sum_clr, sum_add, sum_zero;
    logic [DW-1:0] sum_val;
    logic          take;

    esc_pkt_class #(
        .DW(DW), .START_CODE(START_CODE), .END_CODE(END_CODE), .ESC_CODE(ESC_CODE)
    ) u_class (
        .byte_i  (in_byte),
        .is_start(is_start),
        .is_end  (is_end),
        .is_esc  (is_esc)
    );

    esc_pkt_sum #(.DW(DW)) u_sum (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sum_clr),
        .add  (sum_add),
        .din  (in_byte),
        .sum_q(sum_val),
        .zero (sum_zero)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        r_d.done  = 1'b0;
        r_d.bad   = 1'b0;
        r_d.ovf   = 1'b0;
        sum_clr   = 1'b0;
        sum_add   = 1'b0;
        take      = 1'b0;
        if (in_valid) begin
            unique case (r_q.state)
                ST_HUNT: begin
                    if (is_start) r_d.state = ST_PAIR;
                end
                ST_PAIR: begin
                    if (is_start) begin
                        r_d.state = ST_BODY;
                        r_d.cnt   = '0;
                        sum_clr   = 1'b1;
                    end else begin
                        r_d.state = ST_HUNT;
                    end
                end
                ST_BODY: begin
                    if (is_start) begin
                        r_d.state = ST_PAIR;
                    end else if (is_end) begin
                        r_d.state = ST_HUNT;
                        if (r_q.cnt == '0) begin
                            r_d.done = 1'b1;
                            r_d.len  = '0;
                        end else if (sum_zero) begin
                            r_d.done = 1'b1;
                            r_d.len  = r_q.cnt - 1'b1;
                        end else begin
                            r_d.bad = 1'b1;
                        end
                    end else if (is_esc) begin
                        r_d.state = ST_ESC;
                    end else begin
                        take = 1'b1;
                    end
                end
                ST_ESC: begin
                    r_d.state = ST_BODY;
                    take      = 1'b1;
                end
                default: r_d.state = ST_HUNT;
            endcase
            if (take) begin
                if (r_q.cnt == CW'(MAX_DATA)) begin
                    r_d.ovf   = 1'b1;
                    r_d.state = ST_HUNT;
                end else begin
                    r_d.wr_en   = 1'b1;
                    r_d.wr_addr = r_q.cnt;
                    r_d.wr_data = in_byte;
                    r_d.cnt     = r_q.cnt + 1'b1;
                    sum_add     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '{state: ST_HUNT, default: '0};
        else
            r_q <= r_d;
    end

    assign wr_en    = r_q.wr_en;
    assign wr_addr  = r_q.wr_addr;
    assign wr_data  = r_q.wr_data;
    assign pkt_done = r_q.done;
    assign pkt_bad  = r_q.bad;
    assign pkt_len  = r_q.len;
    assign overflow = r_q.ovf;

    // R5: a packet is never both good and bad
    p_done_bad_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_done && pkt_bad));
    // R2: writes stay inside the buffer
    p_addr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < MAX_DATA));
    // R2: back-to-back writes step the address by one
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));
    // R7: the overflowing byte is not written
    p_ovf_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (!wr_en && !pkt_done));
    // R4: the done strobe is a single cycle
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);
    // R10: an idle input cycle produces no output event
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en && !pkt_done && !pkt_bad && !overflow));
endmodule

// File: tb/esc_pkt_deframer_tb.sv
`timescale 1ns/1ps
module esc_pkt_deframer_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       wr_en, pkt_done, pkt_bad, overflow;
    logic [7:0] wr_addr, wr_data, pkt_len;

    always #4 clk = ~clk;

    esc_pkt_deframer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pkt_done(pkt_done), .pkt_bad(pkt_bad), .pkt_len(pkt_len), .overflow(overflow)
    );

    int n_chk = 0, n_bad = 0;
    int m_wr, m_done, m_badp, m_ovf, m_len;
    logic [7:0] shadow [0:254];
    logic [7:0] pay [0:299];
    bit gap_en = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin m_wr++; shadow[wr_addr] = wr_data; end
            if (pkt_done) begin m_done++; m_len = int'(pkt_len); end
            if (pkt_bad) m_badp++;
            if (overflow) m_ovf++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        m_wr = 0; m_done = 0; m_badp = 0; m_ovf = 0; m_len = -1;
    endtask

    task automatic put(input logic [7:0] b);
        if (gap_en && $urandom_range(0, 3) == 0) begin
            in_valid = 1'b0; in_byte = 8'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b1; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic put_data(input logic [7:0] b);
        if (b == 8'h0F || b == 8'h04 || b == 8'h05) put(8'h05);
        put(b);
    endtask

    function automatic logic [7:0] csum(input int n);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < n; i++) s = s + pay[i];
        return 8'h00 - s;
    endfunction

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic send_frame(input int n, input bit corrupt);
        logic [7:0] c;
        c = csum(n);
        if (corrupt) c = c + 8'h01;
        put(8'h0F); put(8'h0F);
        for (int i = 0; i < n; i++) put_data(pay[i]);
        put_data(c);
        put(8'h04);
        settle();
    endtask

    task automatic expect_good(input int n, input string tag);
        int mis = 0;
        chk(m_done == 1, {tag, " done count"}, m_done, 1);
        chk(m_badp == 0, {tag, " bad count"}, m_badp, 0);
        chk(m_len == n, {tag, " length"}, m_len, n);
        chk(m_wr == n + 1, {tag, " write count"}, m_wr, n + 1);
        for (int i = 0; i < n; i++) if (shadow[i] !== pay[i]) mis++;
        if (shadow[n] !== csum(n)) mis++;
        chk(mis == 0, {tag, " buffer image"}, mis, 0);
    endtask

    initial begin
        #(8ns * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        bit cor;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
        clr_mon();
        repeat (3) @(negedge clk);
        chk(!wr_en && !pkt_done && !pkt_bad && !overflow, "R9 reset outputs",
            int'({wr_en, pkt_done, pkt_bad, overflow}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: payload holding every control value
        clr_mon();
        pay[0] = 8'h0F; pay[1] = 8'h04; pay[2] = 8'h05; pay[3] = 8'hA5; pay[4] = 8'h0F;
        send_frame(5, 1'b0);
        expect_good(5, "R3 escaped controls");

        // R5: corrupted checksum
        clr_mon();
        pay[0] = 8'h11; pay[1] = 8'h22;
        send_frame(2, 1'b1);
        chk(m_badp == 1, "R5 bad pulse", m_badp, 1);
        chk(m_done == 0, "R5 no done on mismatch", m_done, 0);

        // R6: empty packet
        clr_mon();
        put(8'h0F); put(8'h0F); put(8'h04); settle();
        chk(m_done == 1 && m_len == 0, "R6 empty done len", m_len, 0);
        chk(m_wr == 0, "R6 no write", m_wr, 0);

        // R4: checksum-only packet, length 0 with one write
        clr_mon();
        send_frame(0, 1'b0);
        expect_good(0, "R4 checksum only");

        // R1: a lone start code opens nothing
        clr_mon();
        put(8'h0F); put(8'h11); put(8'h22); put(8'hEF); put(8'h04); settle();
        chk(m_wr == 0 && m_done == 0 && m_badp == 0, "R1 lone start ignored",
            m_wr + m_done + m_badp, 0);

        // R8: restart mid-packet
        clr_mon();
        put(8'h0F); put(8'h0F); put(8'hAA); put(8'hBB);
        pay[0] = 8'h31; pay[1] = 8'h32; pay[2] = 8'h33;
        send_frame(3, 1'b0);
        chk(m_wr == 6, "R8 writes across restart", m_wr, 6);
        chk(m_done == 1 && m_len == 3, "R8 restarted length", m_len, 3);
        chk(shadow[0] == 8'h31 && shadow[3] == csum(3), "R8 count reset",
            int'(shadow[0]), 'h31);

        // R7: 256 data bytes
        clr_mon();
        put(8'h0F); put(8'h0F);
        for (int i = 0; i < 256; i++) put(8'h00);
        put(8'h04); settle();
        chk(m_ovf == 1, "R7 overflow pulse", m_ovf, 1);
        chk(m_wr == 255, "R7 write count", m_wr, 255);
        chk(m_done == 0 && m_badp == 0, "R7 end ignored", m_done + m_badp, 0);

        // R7 R3: escaped byte is the overflowing one
        clr_mon();
        put(8'h0F); put(8'h0F);
        for (int i = 0; i < 255; i++) put(8'h00);
        put(8'h05); put(8'h0F); put(8'h04); settle();
        chk(m_ovf == 1 && m_wr == 255, "R7 escaped overflow", m_wr, 255);
        chk(m_done == 0 && m_badp == 0, "R7 escaped end ignored", m_done + m_badp, 0);

        // R10 and random packets with idle gaps
        gap_en = 1'b1;
        for (int k = 0; k < 40; k++) begin
            n = $urandom_range(0, 30);
            cor = ($urandom_range(0, 4) == 0);
            for (int i = 0; i < n; i++) begin
                case ($urandom_range(0, 5))
                    0: pay[i] = 8'h0F;
                    1: pay[i] = 8'h04;
                    2: pay[i] = 8'h05;
                    default: pay[i] = 8'($urandom);
                endcase
            end
            clr_mon();
            send_frame(n, cor);
            if (cor) begin
                chk(m_badp == 1 && m_done == 0, "R5 R10 random bad", m_badp, 1);
            end else begin
                expect_good(n, "R2 R10 random");
            end
        end
        gap_en = 1'b0;

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule